// File: doc/BRIEF.md
# Multi-Slot Converter Scan Sequencer

This block steps an analog-to-digital converter through a scan of up to eight programmable slots. Each slot carries an enable, a converter channel number, a track-and-hold delay code and an averaging code. A scan starts on a trigger. The trigger is an edge of one of eight external lines, with the edge direction selectable, or a software write of a key byte. The sequencer then visits the enabled slots in ascending index order. Before each conversion it waits out the slot's hold delay. It then runs the number of conversions the slot asks for, adds the samples and shifts the sum right to form the average.

The converter itself sits outside the block. The sequencer drives it through a one-cycle start pulse with a channel number and accepts one result on a one-cycle done pulse. Each slot's average leaves the block as a one-cycle result strobe tagged with the slot index, and the end of a scan is marked by its own pulse. In repeating mode, the trigger that starts the first scan arms the block. After that, every tick of an external pacing input starts another scan, until pacing or the block itself is switched off.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, `busy`, `conv_start`, `res_valid` and `scan_done` are all 0.
- R2: Slots are visited in ascending index order and disabled slots are skipped. Each result carries its slot index (0 to 7) on `res_slot`.
- R3: A hold code h (0 to 7) makes the sequencer wait 2^h cycles before every conversion of the slot. After a `conv_done` sampled at a clock edge, the next `conv_start` of the same slot is seen 2^h+1 cycles later.
- R4: An averaging code a (0 to 7) makes the slot run 2^a conversions. The result is the sum of the samples shifted right by a, which keeps 12 bits.
- R5: `trig_sel` codes 0 to 7 pick external line `ext_trig[code]`. `trig_pol`=0 starts a scan on a rising edge and `trig_pol`=1 on a falling edge. Activity on the other lines, or an edge of the wrong direction, starts nothing.
- R6: When `trig_sel`=8, a cycle with `sw_wr`=1 and `sw_data`=8'h37 starts a scan. Any other byte, or the key byte written under another `trig_sel`, starts nothing.
- R7: In single mode (`repeat_mode`=0), each trigger gives exactly one scan. Triggers and pacing ticks that arrive while a scan runs, or in single mode, are ignored.
- R8: In repeating mode (`repeat_mode`=1), a trigger accepted while `pace_en`=1 arms the block, and each later `pace_tick` seen while idle starts a scan. Dropping `pace_en` disarms it, and raising `pace_en` again does not re-arm it.
- R9: A scan with no enabled slot gives no result and still pulses `scan_done`.
- R10: `res_valid` pulses once per enabled slot. `scan_done` pulses once, after the last result and never in the same cycle as a result, and `busy` is 0 in that cycle.
- R11: With `enable`=0, triggers are ignored. Clearing `enable` during a scan aborts it, and `busy` and `conv_start` are 0 from the next cycle on.
- R12: `conv_start` is a single-cycle pulse issued only while busy, and `conv_chan` holds the channel of the slot being converted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Global enable, aborts a scan when low |
| repeat_mode | input | 1 | 1: timer-paced repeating scans |
| trig_sel | input | 4 | Trigger source: 0..7 external line, 8 software |
| trig_pol | input | 1 | 0 rising edge, 1 falling edge |
| ext_trig | input | 8 | External trigger lines |
| sw_wr | input | 1 | Software trigger write strobe |
| sw_data | input | 8 | Software trigger write byte |
| pace_en | input | 1 | Pacing timer running |
| pace_tick | input | 1 | Pacing timer tick |
| slot_en | input | 8 | Per-slot enable |
| slot_chan | input | 32 | Per-slot channel, 4 bits per slot, slot i at [4i+3:4i] |
| slot_hold | input | 24 | Per-slot hold code, 3 bits per slot |
| slot_avg | input | 24 | Per-slot averaging code, 3 bits per slot |
| conv_start | output | 1 | Converter start pulse |
| conv_chan | output | 4 | Channel for the converter |
| conv_done | input | 1 | Converter done pulse |
| conv_data | input | 12 | Converter sample, valid with conv_done |
| busy | output | 1 | Scan in progress |
| res_valid | output | 1 | Slot result strobe |
| res_data | output | 12 | Averaged slot result |
| res_slot | output | 3 | Slot index of the result |
| scan_done | output | 1 | Scan complete pulse |

## Verification
The hardest situation to reach from the ports is a pacing tick that must be ignored because the armed state was lost. The lost arming cannot be seen directly, only through its absence of effect. The stimulus therefore runs two paced scans in repeating mode, drops `pace_en`, raises it again and ticks, then checks that no scan or result follows. A second stimulus of the same kind times a rising edge on the selected line so that it lands while a long multi-slot scan is busy. A scoreboard computes each slot's average from the channel-dependent sample model of the converter, so a skipped, repeated or reordered conversion shows up as a data mismatch.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_HOLD,
    ST_WAIT
  } seq_state_e;
endpackage

// File: rtl/adc_trig_unit.sv
module adc_trig_unit #(
  parameter int NEXT  = 8,
  parameter int TSELW = 4,
  parameter logic [7:0] SW_KEY = 8'h37
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             repeat_mode,
  input  logic [TSELW-1:0] trig_sel,
  input  logic             trig_pol,
  input  logic [NEXT-1:0]  ext_trig,
  input  logic             sw_wr,
  input  logic [7:0]       sw_data,
  input  logic             pace_en,
  input  logic             pace_tick,
  input  logic             busy,
  output logic             start
);
  logic [NEXT-1:0] ext_q;
  logic sel_now, sel_prev, edge_hit, sw_hit, first_hit, pace_hit, can_go;
  logic armed;

  always_comb begin
    sel_now  = 1'b0;
    sel_prev = 1'b0;
    for (int i = 0; i < NEXT; i++) begin
      if (trig_sel == TSELW'(i)) begin
        sel_now  = ext_trig[i];
        sel_prev = ext_q[i];
      end
    end
  end

  assign edge_hit  = trig_pol ? (sel_prev & ~sel_now) : (sel_now & ~sel_prev);
  assign sw_hit    = sw_wr && (sw_data == SW_KEY) && (trig_sel == TSELW'(NEXT));
  assign first_hit = edge_hit | sw_hit;
  assign pace_hit  = armed & pace_en & pace_tick;
  assign can_go    = enable && !busy && !start;

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_q <= '0;
      start <= 1'b0;
      armed <= 1'b0;
    end else begin
      ext_q <= ext_trig;
      start <= can_go && (first_hit || pace_hit);
      if (!enable || !pace_en || !repeat_mode)
        armed <= 1'b0;
      else if (can_go && first_hit)
        armed <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_avg_acc.sv
module adc_avg_acc #(
  parameter int DW   = 12,
  parameter int SELW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            add,
  input  logic [DW-1:0]   din,
  input  logic [SELW-1:0] shift,
  output logic [DW-1:0]   avg_out
);
  localparam int ACCW = DW + (1 << SELW) - 1;

  logic [ACCW-1:0] acc;
  logic [ACCW-1:0] sum_w;

  assign sum_w   = acc + ACCW'(din);
  assign avg_out = DW'(sum_w >> shift);

  always_ff @(posedge clk) begin
    if (rst || clr) acc <= '0;
    else if (add)   acc <= sum_w;
  end
endmodule

// File: rtl/adc_slot_fsm.sv
module adc_slot_fsm
  import adc_seq_pkg::*;
#(
  parameter int NSLOT = 8,
  parameter int CHW   = 4,
  parameter int SELW  = 3,
  parameter int DW    = 12
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           enable,
  input  logic                           start,
  input  logic [NSLOT-1:0]               slot_en,
  input  logic [NSLOT-1:0][CHW-1:0]      slot_chan,
  input  logic [NSLOT-1:0][SELW-1:0]     slot_hold,
  input  logic [NSLOT-1:0][SELW-1:0]     slot_avg,
  input  logic                           conv_done,
  input  logic [DW-1:0]                  avg_in,
  output logic                           acc_clr,
  output logic                           acc_add,
  output logic [SELW-1:0]                cur_avg,
  output logic                           busy,
  output logic                           conv_start,
  output logic [CHW-1:0]                 conv_chan,
  output logic                           res_valid,
  output logic [DW-1:0]                  res_data,
  output logic [$clog2(NSLOT)-1:0]       res_slot,
  output logic                           scan_done
);
  localparam int SLW  = $clog2(NSLOT);
  localparam int IDXW = SLW + 1;
  localparam int CNTW = (1 << SELW) - 1;

  seq_state_e        state;
  logic [IDXW-1:0]   idx;
  logic [SLW-1:0]    idx_lo;
  logic              in_range;
  logic [CNTW-1:0]   cnt;
  logic [CNTW-1:0]   mcnt;
  logic [SELW-1:0]   cur_hold;

  assign idx_lo   = idx[SLW-1:0];
  assign in_range = idx < IDXW'(NSLOT);
  assign busy     = (state != ST_IDLE);
  assign acc_clr  = (state == ST_IDLE) || (state == ST_SCAN);
  assign acc_add  = (state == ST_WAIT) && conv_done;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      state      <= ST_IDLE;
      idx        <= '0;
      cnt        <= '0;
      mcnt       <= '0;
      cur_hold   <= '0;
      cur_avg    <= '0;
      conv_start <= 1'b0;
      conv_chan  <= '0;
      res_valid  <= 1'b0;
      res_data   <= '0;
      res_slot   <= '0;
      scan_done  <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      res_valid  <= 1'b0;
      scan_done  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            idx   <= '0;
            state <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (!in_range) begin
            scan_done <= 1'b1;
            state     <= ST_IDLE;
          end else if (slot_en[idx_lo]) begin
            cur_hold  <= slot_hold[idx_lo];
            cur_avg   <= slot_avg[idx_lo];
            conv_chan <= slot_chan[idx_lo];
            cnt       <= CNTW'((32'd1 << slot_hold[idx_lo]) - 32'd1);
            mcnt      <= '0;
            state     <= ST_HOLD;
          end else begin
            idx <= idx + IDXW'(1);
          end
        end
        ST_HOLD: begin
          if (cnt == '0) begin
            conv_start <= 1'b1;
            state      <= ST_WAIT;
          end else begin
            cnt <= cnt - CNTW'(1);
          end
        end
        ST_WAIT: begin
          if (conv_done) begin
            if (mcnt == CNTW'((32'd1 << cur_avg) - 32'd1)) begin
              res_valid <= 1'b1;
              res_data  <= avg_in;
              res_slot  <= idx_lo;
              idx       <= idx + IDXW'(1);
              state     <= ST_SCAN;
            end else begin
              mcnt  <= mcnt + CNTW'(1);
              cnt   <= CNTW'((32'd1 << cur_hold) - 32'd1);
              state <= ST_HOLD;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int NSLOT = 8,
  parameter int NEXT  = 8,
  parameter int CHW   = 4,
  parameter int SELW  = 3,
  parameter int DW    = 12,
  parameter int TSELW = 4,
  parameter logic [7:0] SW_KEY = 8'h37
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     enable,
  input  logic                     repeat_mode,
  input  logic [TSELW-1:0]         trig_sel,
  input  logic                     trig_pol,
  input  logic [NEXT-1:0]          ext_trig,
  input  logic                     sw_wr,
  input  logic [7:0]               sw_data,
  input  logic                     pace_en,
  input  logic                     pace_tick,
  input  logic [NSLOT-1:0]         slot_en,
  input  logic [NSLOT*CHW-1:0]     slot_chan,
  input  logic [NSLOT*SELW-1:0]    slot_hold,
  input  logic [NSLOT*SELW-1:0]    slot_avg,
  output logic                     conv_start,
  output logic [CHW-1:0]           conv_chan,
  input  logic                     conv_done,
  input  logic [DW-1:0]            conv_data,
  output logic                     busy,
  output logic                     res_valid,
  output logic [DW-1:0]            res_data,
  output logic [$clog2(NSLOT)-1:0] res_slot,
  output logic                     scan_done
);
  logic [NSLOT-1:0][CHW-1:0]  chan_a;
  logic [NSLOT-1:0][SELW-1:0] hold_a;
  logic [NSLOT-1:0][SELW-1:0] avg_a;
  logic                       start;
  logic                       acc_clr, acc_add;
  logic [SELW-1:0]            cur_avg;
  logic [DW-1:0]              avg_val;

  for (genvar s = 0; s < NSLOT; s++) begin : g_unpack
    assign chan_a[s] = slot_chan[s*CHW +: CHW];
    assign hold_a[s] = slot_hold[s*SELW +: SELW];
    assign avg_a[s]  = slot_avg[s*SELW +: SELW];
  end

  adc_trig_unit #(.NEXT(NEXT), .TSELW(TSELW), .SW_KEY(SW_KEY)) u_trig (
    .clk(clk), .rst(rst), .enable(enable), .repeat_mode(repeat_mode),
    .trig_sel(trig_sel), .trig_pol(trig_pol), .ext_trig(ext_trig),
    .sw_wr(sw_wr), .sw_data(sw_data), .pace_en(pace_en),
    .pace_tick(pace_tick), .busy(busy), .start(start)
  );

  adc_avg_acc #(.DW(DW), .SELW(SELW)) u_acc (
    .clk(clk), .rst(rst), .clr(acc_clr), .add(acc_add),
    .din(conv_data), .shift(cur_avg), .avg_out(avg_val)
  );

  adc_slot_fsm #(.NSLOT(NSLOT), .CHW(CHW), .SELW(SELW), .DW(DW)) u_fsm (
    .clk(clk), .rst(rst), .enable(enable), .start(start),
    .slot_en(slot_en), .slot_chan(chan_a), .slot_hold(hold_a),
    .slot_avg(avg_a), .conv_done(conv_done), .avg_in(avg_val),
    .acc_clr(acc_clr), .acc_add(acc_add), .cur_avg(cur_avg),
    .busy(busy), .conv_start(conv_start), .conv_chan(conv_chan),
    .res_valid(res_valid), .res_data(res_data), .res_slot(res_slot),
    .scan_done(scan_done)
  );
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk (
  input logic clk,
  input logic rst,
  input logic enable,
  input logic busy,
  input logic conv_start,
  input logic res_valid,
  input logic scan_done
);
  // R12
  conv_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);
  // R12
  conv_busy_chk: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> busy);
  // R10
  res_busy_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> busy);
  // R10
  done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    scan_done |-> (!res_valid && !busy));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    scan_done |=> !scan_done);
  // R11
  off_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!busy && !conv_start && !res_valid));
endmodule

bind adc_scan_seq adc_scan_seq_chk u_chk (
  .clk(clk), .rst(rst), .enable(enable), .busy(busy),
  .conv_start(conv_start), .res_valid(res_valid), .scan_done(scan_done)
);

// File: tb/adc_scan_seq_tb.sv
module adc_scan_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst = 1;
  logic        enable = 0, repeat_mode = 0, trig_pol = 0;
  logic [3:0]  trig_sel = 0;
  logic [7:0]  ext_trig = 0;
  logic        sw_wr = 0;
  logic [7:0]  sw_data = 0;
  logic        pace_en = 0, pace_tick = 0;
  logic [7:0]  slot_en = 0;
  logic [31:0] slot_chan = 0;
  logic [23:0] slot_hold = 0, slot_avg = 0;
  logic        conv_start, conv_done = 0;
  logic [3:0]  conv_chan;
  logic [11:0] conv_data = 0;
  logic        busy, res_valid, scan_done;
  logic [11:0] res_data;
  logic [2:0]  res_slot;

  adc_scan_seq u_dut (
    .clk(clk), .rst(rst), .enable(enable), .repeat_mode(repeat_mode),
    .trig_sel(trig_sel), .trig_pol(trig_pol), .ext_trig(ext_trig),
    .sw_wr(sw_wr), .sw_data(sw_data), .pace_en(pace_en), .pace_tick(pace_tick),
    .slot_en(slot_en), .slot_chan(slot_chan), .slot_hold(slot_hold),
    .slot_avg(slot_avg), .conv_start(conv_start), .conv_chan(conv_chan),
    .conv_done(conv_done), .conv_data(conv_data), .busy(busy),
    .res_valid(res_valid), .res_data(res_data), .res_slot(res_slot),
    .scan_done(scan_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { int slot; int data; } exp_t;
  exp_t sb[$];

  int total = 0, bad = 0, scans = 0, gc = 0, egc = 0, ncyc = 0;
  int t_done = 0, last_gap = 0;
  bit finished = 0;
  int c_en[8], c_ch[8], c_h[8], c_a[8];

  function automatic int sample_of(int ch, int n);
    return (ch * 293 + n * 1187 + 5) & 12'hFFF;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply_cfg();
    @(negedge clk);
    for (int s = 0; s < 8; s++) begin
      slot_en[s]          = c_en[s][0];
      slot_chan[s*4 +: 4] = c_ch[s][3:0];
      slot_hold[s*3 +: 3] = c_h[s][2:0];
      slot_avg[s*3 +: 3]  = c_a[s][2:0];
    end
  endtask

  task automatic clear_cfg();
    for (int s = 0; s < 8; s++) begin
      c_en[s] = 0; c_ch[s] = 0; c_h[s] = 0; c_a[s] = 0;
    end
  endtask

  // Driver side of the scoreboard: predicts one scan's results.
  task automatic expect_scan();
    for (int s = 0; s < 8; s++) begin
      if (c_en[s] != 0) begin
        int sum;
        exp_t e;
        sum = 0;
        for (int k = 0; k < (1 << c_a[s]); k++) begin
          sum += sample_of(c_ch[s], egc);
          egc++;
        end
        e.slot = s;
        e.data = sum >> c_a[s];
        sb.push_back(e);
      end
    end
  endtask

  task automatic wait_scans(int n);
    while (scans < n) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_ext(int i);
    @(negedge clk); ext_trig[i] = 1'b1;
    @(negedge clk); ext_trig[i] = 1'b0;
  endtask

  task automatic sw_write(int v);
    @(negedge clk); sw_wr = 1'b1; sw_data = v[7:0];
    @(negedge clk); sw_wr = 1'b0; sw_data = 8'h00;
  endtask

  task automatic tick();
    @(negedge clk); pace_tick = 1'b1;
    @(negedge clk); pace_tick = 1'b0;
  endtask

  // Converter model: answers each start with one done a cycle later.
  initial begin
    forever begin
      @(negedge clk);
      ncyc++;
      if (conv_done) conv_done = 1'b0;
      if (conv_start) begin
        last_gap  = ncyc - t_done;
        conv_data = sample_of(int'(conv_chan), gc)[11:0];
        gc++;
        conv_done = 1'b1;
        t_done    = ncyc;
      end
    end
  end

  // Monitor side of the scoreboard.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (res_valid) begin
          if (sb.size() == 0) begin
            check(0, "R7 R11 unexpected result slot", int'(res_slot), -1);
          end else begin
            exp_t e;
            e = sb.pop_front();
            check(int'(res_slot) == e.slot, "R2 result slot", int'(res_slot), e.slot);
            check(int'(res_data) == e.data, "R4 R12 result data", int'(res_data), e.data);
          end
        end
        if (scan_done) scans++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int s0;
    clear_cfg();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(busy == 0, "R1 busy", busy, 0);
    check(conv_start == 0, "R1 conv_start", conv_start, 0);
    check(res_valid == 0, "R1 res_valid", res_valid, 0);
    check(scan_done == 0, "R1 scan_done", scan_done, 0);
    enable = 1'b1;

    // R2 R5 rising edge on line 2, three slots out of order of enable
    c_en[1] = 1; c_ch[1] = 5;  c_h[1] = 1; c_a[1] = 2;
    c_en[4] = 1; c_ch[4] = 12; c_h[4] = 0; c_a[4] = 0;
    c_en[6] = 1; c_ch[6] = 8;  c_h[6] = 2; c_a[6] = 1;
    apply_cfg();
    trig_sel = 4'd2; trig_pol = 1'b0;
    s0 = scans;
    expect_scan();
    pulse_ext(2);
    while (!busy) @(negedge clk);
    pulse_ext(2);  // R7 retrigger while busy must be ignored
    wait_scans(s0 + 1);
    repeat (30) @(negedge clk);
    check(scans == s0 + 1, "R7 one scan per trigger", scans - s0, 1);
    check(sb.size() == 0, "R10 all results delivered", sb.size(), 0);

    // R5 falling polarity: rising edge ignored, falling edge starts
    trig_pol = 1'b1;
    s0 = scans;
    @(negedge clk); ext_trig[2] = 1'b1;
    repeat (20) @(negedge clk);
    check(busy == 0 && scans == s0, "R5 rising ignored when falling selected", scans - s0, 0);
    expect_scan();
    @(negedge clk); ext_trig[2] = 1'b0;
    wait_scans(s0 + 1);
    check(scans == s0 + 1, "R5 falling edge scan", scans - s0, 1);

    // R5 other line ignored
    s0 = scans;
    pulse_ext(5);
    @(negedge clk); ext_trig[5] = 1'b1;
    @(negedge clk); ext_trig[5] = 1'b0;
    repeat (20) @(negedge clk);
    check(scans == s0 && busy == 0, "R5 unselected line ignored", scans - s0, 0);

    // R6 software trigger key
    trig_sel = 4'd8;
    s0 = scans;
    sw_write(8'h36);
    repeat (20) @(negedge clk);
    check(scans == s0, "R6 wrong key ignored", scans - s0, 0);
    expect_scan();
    sw_write(8'h37);
    wait_scans(s0 + 1);
    check(scans == s0 + 1, "R6 key starts scan", scans - s0, 1);
    trig_sel = 4'd3;
    s0 = scans;
    sw_write(8'h37);
    repeat (20) @(negedge clk);
    check(scans == s0, "R6 key ignored under external select", scans - s0, 0);

    // R9 empty scan
    clear_cfg(); apply_cfg();
    trig_sel = 4'd8;
    s0 = scans;
    sw_write(8'h37);
    wait_scans(s0 + 1);
    check(scans == s0 + 1, "R9 empty scan completes", scans - s0, 1);

    // R4 deep averaging at both ends of the slot range
    c_en[0] = 1; c_ch[0] = 3;  c_h[0] = 2; c_a[0] = 3;
    c_en[7] = 1; c_ch[7] = 10; c_h[7] = 0; c_a[7] = 7;
    apply_cfg();
    s0 = scans;
    expect_scan();
    sw_write(8'h37);
    wait_scans(s0 + 1);
    check(sb.size() == 0, "R4 averaging results delivered", sb.size(), 0);

    // R3 hold delay between conversions
    clear_cfg();
    c_en[3] = 1; c_ch[3] = 7; c_h[3] = 3; c_a[3] = 1;
    apply_cfg();
    s0 = scans;
    expect_scan();
    sw_write(8'h37);
    wait_scans(s0 + 1);
    check(last_gap == 9, "R3 hold code 3 gap", last_gap, 9);
    c_h[3] = 0;
    apply_cfg();
    s0 = scans;
    expect_scan();
    sw_write(8'h37);
    wait_scans(s0 + 1);
    check(last_gap == 2, "R3 hold code 0 gap", last_gap, 2);

    // R8 repeating mode paced by ticks
    clear_cfg();
    c_en[2] = 1; c_ch[2] = 9; c_h[2] = 0; c_a[2] = 0;
    apply_cfg();
    repeat_mode = 1'b1; pace_en = 1'b1;
    s0 = scans;
    expect_scan();
    sw_write(8'h37);
    wait_scans(s0 + 1);
    expect_scan();
    tick();
    wait_scans(s0 + 2);
    expect_scan();
    tick();
    wait_scans(s0 + 3);
    check(scans == s0 + 3, "R8 paced scans", scans - s0, 3);
    @(negedge clk); pace_en = 1'b0;
    tick();
    repeat (20) @(negedge clk);
    @(negedge clk); pace_en = 1'b1;
    tick();
    repeat (20) @(negedge clk);
    check(scans == s0 + 3, "R8 pacing off disarms", scans - s0, 3);

    // R7 single mode ignores ticks
    repeat_mode = 1'b0;
    s0 = scans;
    expect_scan();
    sw_write(8'h37);
    wait_scans(s0 + 1);
    tick();
    repeat (20) @(negedge clk);
    check(scans == s0 + 1, "R7 tick ignored in single mode", scans - s0, 1);
    pace_en = 1'b0;

    // R11 disabled block ignores triggers
    @(negedge clk); enable = 1'b0;
    s0 = scans;
    sw_write(8'h37);
    repeat (20) @(negedge clk);
    check(scans == s0 && busy == 0, "R11 trigger ignored when disabled", scans - s0, 0);

    // R11 abort mid-scan
    @(negedge clk); enable = 1'b1;
    c_a[2] = 6;
    apply_cfg();
    sw_write(8'h37);
    repeat (20) @(negedge clk);
    check(busy == 1, "R11 long scan running", busy, 1);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    check(busy == 0 && conv_start == 0, "R11 abort clears busy", busy, 0);
    repeat (5) @(negedge clk);
    check(scans == s0, "R11 aborted scan has no done", scans - s0, 0);
    sb.delete();
    egc = gc;

    // R2 R10 after abort, a fresh scan still works
    @(negedge clk); enable = 1'b1;
    c_a[2] = 0;
    c_en[5] = 1; c_ch[5] = 1; c_h[5] = 1; c_a[5] = 2;
    apply_cfg();
    s0 = scans;
    expect_scan();
    sw_write(8'h37);
    wait_scans(s0 + 1);
    check(sb.size() == 0, "R10 results after recovery", sb.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule